// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a single-clock static RAM with byte-lane writes, a two-bit interleaved burst counter and a registered read path. Every address, data and control input is taken on the rising clock edge. The one exception is the active-low output enable, which gates the data drivers with no clock in the path. The shared data bus is split into a write-data input, a read-data output and an output-enable flag. A board-level wrapper would join them into one tristate bus.

A burst opens in one of two ways. The first is a processor-side start strobe, which takes effect only while chip select is low and always reads. The second is a controller-side start strobe, which reads or writes according to the byte write enables. Once a burst is open, cycles with neither strobe active either step the burst counter or hold it, and each one reads or writes the current word. The word is 18 bits wide and made of two 9-bit lanes. The address width is a parameter: its default of 10 bits gives a 1024-word array, and a value of 16 gives the full 64K-word part.

Top module: `burst_sram`

## Requirements
- R1: Byte lanes: lane A is bits 8:0 and lane B is bits 17:9. In a write cycle, `we_a_n` low writes lane A and `we_b_n` low writes lane B, and both low write all 18 bits. A lane whose enable is high keeps its old contents. With both enables high the cycle is a read.
- R2: With `cs_n`=0 and `ads_proc_n`=0, a read burst opens at `addr` with the burst counter at 0. The write enables are ignored in that cycle, and no array word changes.
- R3: `ads_proc_n` has no effect while `cs_n`=1; such a cycle with `ads_ctrl_n`=1 acts as a continue cycle. When the processor strobe is not in effect and `cs_n`=0, `ads_ctrl_n`=0 opens a burst at `addr`. That cycle writes if either write enable is low and reads otherwise.
- R4: `cs_n`=1 with `ads_ctrl_n`=0 is a deselect cycle. No word is written in it, even with write enables low. Later continue cycles do nothing until a new burst opens.
- R5: A continue cycle is one where neither start strobe is in effect, inside an open burst. With `adv_n`=0 it first steps the counter and then accesses the new address. With `adv_n`=1 it accesses the current address again. In both cases the write enables choose read or write as in R1.
- R6: The n-th access of a burst uses address bits 1:0 equal to the start bits XOR n, and the upper bits of the start address. After the fourth address the counter wraps to n=0 and never carries into bit 2.
- R7: A read sampled at edge k shows its word on `dout` after edge k+1. The word is the array contents as left by all accesses sampled at edges before k+1.
- R8: `dout_en` is high exactly when the output register holds valid read data and `oe_n` is low. `oe_n` acts without waiting for a clock edge.
- R9: A write cycle clears the output-valid state at its own edge, so `dout_en` falls after that first edge.
- R10: After a deselect cycle at edge k, the bus stays driven with any read result loaded at edge k. It is released at edge k+1.
- R11: While `rst_n` is low and after it is released, no burst is open, the counter is 0 and `dout_en` is low until a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | External start address |
| din | input | 2*LANE_W | Write data |
| we_a_n | input | 1 | Active-low write enable, lane A (bits 8:0) |
| we_b_n | input | 1 | Active-low write enable, lane B (bits 17:9) |
| oe_n | input | 1 | Asynchronous active-low output enable |
| cs_n | input | 1 | Active-low chip select; also gates the processor strobe |
| ads_proc_n | input | 1 | Processor-side burst start strobe, read only, higher priority |
| ads_ctrl_n | input | 1 | Controller-side burst start strobe |
| adv_n | input | 1 | Active-low burst advance |
| dout | output | 2*LANE_W | Registered read data |
| dout_en | output | 1 | Data driver enable (high = drive bus) |

## Verification
A wrong burst counter or base register shows as a wrong word on `dout` one edge after the first misaddressed read. A wrong counter in a write burst shows only when those words are read back later. A lost or spurious write shows at the next read of that word. A wrong output-valid state shows on `dout_en` right after the edge that ends a write or deselect cycle. The bench keeps a full reference array and checks every cycle, so each fault shows at the first access that reaches it.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
// Package: shared access type for the burst SRAM model.
// Assumes: one access (or none) is decoded per clock edge.
package burst_sram_pkg;

    // Kind of array access decoded for the current edge
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } acc_op_e;

    // Width of the interleaved burst counter (four beats)
    localparam int BURST_W = 2;

endpackage

// File: rtl/burst_sram_ctrl.sv
`timescale 1ns/1ps
// Module: burst_sram_ctrl
// Decodes the start strobes and chip select, keeps the burst base address
// and the interleave counter, and gives out the access type and address
// for the current edge (combinational from the sampled inputs).
// Assumes: the processor strobe only counts when chip select is low, and it
// beats the controller strobe. Continue cycles outside an open burst are idle.
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              ads_proc_n,
    input  logic              ads_ctrl_n,
    input  logic              adv_n,
    input  logic              we_any,
    output acc_op_e           acc_op,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [CNT_W-1:0]  cnt,
    output logic              sel
);

    logic [ADDR_W-1:0] base_q, base_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              sel_q, sel_d;
    logic              proc_go, ctrl_hit, start, desel, cont;

    // Strobe priority: gated processor strobe first, then controller strobe
    always_comb begin
        proc_go  = !cs_n && !ads_proc_n;
        ctrl_hit = !proc_go && !ads_ctrl_n;
        start    = proc_go || (ctrl_hit && !cs_n);
        desel    = ctrl_hit && cs_n;
        cont     = !proc_go && ads_ctrl_n;
    end

    // Next base, counter and burst-open state, and the access type
    always_comb begin
        base_d = base_q;
        cnt_d  = cnt_q;
        sel_d  = sel_q;
        acc_op = OP_IDLE;
        if (start) begin
            base_d = addr;
            cnt_d  = '0;
            sel_d  = 1'b1;
            acc_op = (proc_go || !we_any) ? OP_READ : OP_WRITE;
        end else if (desel) begin
            sel_d  = 1'b0;
            acc_op = OP_IDLE;
        end else if (cont && sel_q) begin
            if (!adv_n) begin
                cnt_d = cnt_q + 1'b1;
            end
            acc_op = we_any ? OP_WRITE : OP_READ;
        end
    end

    // Interleaved address: low bits XOR the beat count, upper bits fixed
    always_comb begin
        acc_addr = {base_d[ADDR_W-1:CNT_W], base_d[CNT_W-1:0] ^ cnt_d};
    end

    // Burst state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            sel_q  <= 1'b0;
        end else begin
            base_q <= base_d;
            cnt_q  <= cnt_d;
            sel_q  <= sel_d;
        end
    end

    assign cnt = cnt_q;
    assign sel = sel_q;

endmodule

// File: rtl/burst_sram_array.sv
`timescale 1ns/1ps
// Module: burst_sram_array
// Storage split into independent byte lanes, each with its own write
// enable. One write port (synchronous) and one read port (combinational).
// Assumes: contents are not reset; read and write addresses are independent.
module burst_sram_array #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  wr_lane,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Lane write on the clock edge when this lane is enabled
        always_ff @(posedge clk) begin
            if (wr_lane[g]) begin
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        // Lane read, combinational from the registered read address
        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/burst_sram_oreg.sv
`timescale 1ns/1ps
// Module: burst_sram_oreg
// Read pipeline: holds the read address taken at edge k, loads the array
// word into the output register at edge k+1, and gates the driver enable
// with the asynchronous output enable. A write cycle clears the valid flag
// at its own edge.
// Assumes: rd_data is the array word at rd_addr, as it stood before this edge.
module burst_sram_oreg
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_op_e           acc_op,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    logic              rd_pend;
    logic              out_valid;
    logic [DATA_W-1:0] out_q;

    // Control flags of the read pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend   <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            rd_pend   <= (acc_op == OP_READ);
            out_valid <= (acc_op == OP_WRITE) ? 1'b0 : rd_pend;
        end
    end

    // Data path of the read pipeline (no reset needed)
    always_ff @(posedge clk) begin
        rd_addr <= acc_addr;
        if (rd_pend && (acc_op != OP_WRITE)) begin
            out_q <= rd_data;
        end
    end

    assign dout    = out_q;
    assign dout_en = out_valid && !oe_n;

endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
// Module: burst_sram (top)
// Pipelined burst synchronous SRAM with two byte lanes, two burst start
// strobes, an interleaved burst counter and a registered read port.
// Assumes: a single clock domain; oe_n is the only asynchronous input.
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    localparam int DATA_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              we_a_n,
    input  logic              we_b_n,
    input  logic              oe_n,
    input  logic              cs_n,
    input  logic              ads_proc_n,
    input  logic              ads_ctrl_n,
    input  logic              adv_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    localparam int LANES = 2;

    acc_op_e           acc_op;
    logic [ADDR_W-1:0] acc_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [BURST_W-1:0] cnt;
    logic              sel;
    logic              we_any;
    logic [LANES-1:0]  wr_lane;

    // Lane write strobes, only in a decoded write cycle
    always_comb begin
        we_any  = !(we_a_n && we_b_n);
        wr_lane = {!we_b_n, !we_a_n} & {LANES{acc_op == OP_WRITE}};
    end

    burst_sram_ctrl #(
        .ADDR_W (ADDR_W),
        .CNT_W  (BURST_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .cs_n       (cs_n),
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .adv_n      (adv_n),
        .we_any     (we_any),
        .acc_op     (acc_op),
        .acc_addr   (acc_addr),
        .cnt        (cnt),
        .sel        (sel)
    );

    burst_sram_array #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_array (
        .clk     (clk),
        .wr_lane (wr_lane),
        .waddr   (acc_addr),
        .wdata   (din),
        .raddr   (rd_addr),
        .rdata   (rd_data)
    );

    burst_sram_oreg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_oreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_op   (acc_op),
        .acc_addr (acc_addr),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .oe_n     (oe_n),
        .dout     (dout),
        .dout_en  (dout_en)
    );

endmodule

// File: rtl/burst_sram_chk.sv
`timescale 1ns/1ps
// Module: burst_sram_chk
// Property checker bound to burst_sram: strobe decode effects on the burst
// state and bus release timing.
module burst_sram_chk #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             ads_proc_n,
    input logic             ads_ctrl_n,
    input logic             adv_n,
    input logic             we_a_n,
    input logic             we_b_n,
    input logic             oe_n,
    input logic             dout_en,
    input logic [CNT_W-1:0] cnt,
    input logic             sel
);

    logic cont_cyc;
    assign cont_cyc = sel && ads_ctrl_n && (cs_n || ads_proc_n);

    // R2
    proc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ads_proc_n) |=> (cnt == '0 && sel));

    // R4
    desel_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !ads_ctrl_n) |=> !sel);

    // R5
    hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_cyc && adv_n) |=> $stable(cnt));

    // R6
    step_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_cyc && !adv_n) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R8
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !oe_n);

    // R9
    wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && ads_proc_n && !ads_ctrl_n && !(we_a_n && we_b_n)) |=> !dout_en);

    // R10
    desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !ads_ctrl_n) |-> ##2 !dout_en);

endmodule

bind burst_sram burst_sram_chk #(.CNT_W(burst_sram_pkg::BURST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .adv_n      (adv_n),
    .we_a_n     (we_a_n),
    .we_b_n     (we_b_n),
    .oe_n       (oe_n),
    .dout_en    (dout_en),
    .cnt        (cnt),
    .sel        (sel)
);

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
// Bench for burst_sram: directed corner cases plus seeded random traffic,
// checked every cycle against a reference array and pipeline model.
module burst_sram_tb;

    localparam int AW    = 10;
    localparam int DW    = 18;
    localparam int DEPTH = 1 << AW;
    localparam int WD_CYC = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          we_a_n = 1'b1, we_b_n = 1'b1, oe_n = 1'b0;
    logic          cs_n = 1'b1, ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1;
    logic [DW-1:0] dout;
    logic          dout_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    logic [DW-1:0] ref_mem [DEPTH];
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    bit            m_sel = 1'b0, m_pend = 1'b0, m_oval = 1'b0;
    logic [AW-1:0] m_paddr = '0;
    logic [DW-1:0] m_odata = '0;

    always #5 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANE_W(9)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .we_a_n(we_a_n), .we_b_n(we_b_n), .oe_n(oe_n), .cs_n(cs_n),
        .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
        .dout(dout), .dout_en(dout_en)
    );

    // Reference behaviour for one clock edge, from the requirements
    task automatic model_edge(input logic c, p, s, a, wa, wb,
                              input logic [AW-1:0] ad, input logic [DW-1:0] d);
        int op;
        logic [AW-1:0] acc;
        op = 0;
        if (!c && !p) begin
            m_base = ad; m_cnt = 2'd0; m_sel = 1'b1; op = 1;
        end else if (!s) begin
            if (c) begin
                m_sel = 1'b0; op = 0;
            end else begin
                m_base = ad; m_cnt = 2'd0; m_sel = 1'b1;
                op = (wa && wb) ? 1 : 2;
            end
        end else if (m_sel) begin
            if (!a) m_cnt = m_cnt + 2'd1;
            op = (wa && wb) ? 1 : 2;
        end
        acc = {m_base[AW-1:2], m_base[1:0] ^ m_cnt};
        if (op == 2) begin
            m_oval = 1'b0;
        end else begin
            m_oval = m_pend;
            if (m_pend) m_odata = ref_mem[m_paddr];
        end
        if (op == 2) begin
            if (!wa) ref_mem[acc][8:0]  = d[8:0];
            if (!wb) ref_mem[acc][17:9] = d[17:9];
        end
        m_pend  = (op == 1);
        m_paddr = acc;
    endtask

    // Compare the ports with the model after an edge
    task automatic compare(input string tag);
        logic exp_en;
        exp_en = m_oval && !oe_n;
        n_chk++;
        if (dout_en !== exp_en || (exp_en && dout !== m_odata)) begin
            n_bad++;
            $display("FAIL %s: got en=%0b data=%h expected en=%0b data=%h",
                     tag, dout_en, dout, exp_en, m_odata);
        end
    endtask

    // One clock cycle: drive at the falling edge, model the rising edge, check
    task automatic cyc(input string tag, input logic c, p, s, a, wa, wb, o,
                       input logic [AW-1:0] ad, input logic [DW-1:0] d);
        @(negedge clk);
        cs_n = c; ads_proc_n = p; ads_ctrl_n = s; adv_n = a;
        we_a_n = wa; we_b_n = wb; oe_n = o; addr = ad; din = d;
        @(posedge clk);
        model_edge(c, p, s, a, wa, wb, ad, d);
        #2;
        compare(tag);
    endtask

    // Watchdog: a hung run is one failed check
    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no end expected end before %0d cycles", WD_CYC);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4321));
        // R11: reset holds the bus released
        repeat (3) @(negedge clk);
        n_chk++;
        if (dout_en !== 1'b0) begin
            n_bad++;
            $display("FAIL R11: got en=%0b expected en=0", dout_en);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R11: continue cycles with no open burst do nothing
        cyc("R11", 0, 1, 1, 0, 0, 0, 0, 10'h000, 18'h15555);
        cyc("R11", 0, 1, 1, 1, 1, 1, 0, 10'h000, 18'h00000);

        // Fill the array: controller write starts, then three advancing beats
        for (int i = 0; i < DEPTH / 4; i++) begin
            cyc("R3", 0, 1, 0, 1, 0, 0, 0, AW'(i * 4), DW'($urandom));
            for (int j = 0; j < 3; j++)
                cyc("R6", 0, 1, 1, 0, 0, 0, 0, '0, DW'($urandom));
        end

        // R1: full, lane A only, lane B only, then read back
        cyc("R1", 0, 1, 0, 1, 0, 0, 0, 10'h040, 18'h2A5A5);
        cyc("R1", 0, 1, 0, 1, 0, 1, 0, 10'h040, 18'h1FFFF);
        cyc("R1", 0, 1, 0, 1, 1, 0, 0, 10'h040, 18'h00000);
        cyc("R1", 0, 0, 1, 1, 1, 1, 0, 10'h040, 18'h0);
        cyc("R1", 0, 1, 1, 1, 1, 1, 0, 10'h000, 18'h0);

        // R2: processor start with write enables low does not write
        cyc("R2", 0, 0, 1, 1, 0, 0, 0, 10'h041, 18'h3FFFF);
        cyc("R2", 0, 1, 1, 1, 1, 1, 0, 10'h000, 18'h0);
        cyc("R2", 0, 1, 1, 1, 1, 1, 0, 10'h000, 18'h0);

        // R3: processor strobe blocked by chip select acts as continue
        cyc("R3", 0, 1, 0, 1, 1, 1, 0, 10'h050, 18'h0);
        cyc("R3", 1, 0, 1, 0, 1, 1, 0, 10'h123, 18'h0);
        cyc("R3", 0, 1, 1, 1, 1, 1, 0, 10'h000, 18'h0);

        // R4: deselect with writes enabled, then idle continue cycles
        cyc("R4", 0, 1, 0, 1, 0, 0, 0, 10'h060, 18'h12345);
        cyc("R4", 1, 1, 0, 1, 0, 0, 0, 10'h060, 18'h3CCCC);
        cyc("R4", 0, 1, 1, 0, 0, 0, 0, 10'h060, 18'h3CCCC);
        cyc("R4", 0, 1, 1, 1, 0, 0, 0, 10'h060, 18'h3CCCC);
        cyc("R4", 0, 0, 1, 1, 1, 1, 0, 10'h060, 18'h0);
        cyc("R4", 0, 1, 1, 1, 1, 1, 0, 10'h000, 18'h0);

        // R5/R6: interleave from low bits 2'b10, a hold, and a wrap
        cyc("R6", 0, 0, 1, 1, 1, 1, 0, 10'h072, 18'h0);
        cyc("R6", 0, 1, 1, 0, 1, 1, 0, 10'h000, 18'h0);
        cyc("R5", 0, 1, 1, 1, 1, 1, 0, 10'h000, 18'h0);
        cyc("R6", 0, 1, 1, 0, 1, 1, 0, 10'h000, 18'h0);
        cyc("R6", 0, 1, 1, 0, 1, 1, 0, 10'h000, 18'h0);
        cyc("R6", 0, 1, 1, 0, 1, 1, 0, 10'h000, 18'h0);
        cyc("R6", 0, 1, 1, 1, 1, 1, 0, 10'h000, 18'h0);

        // R8: output enable gates the driver
        cyc("R8", 0, 0, 1, 1, 1, 1, 1, 10'h072, 18'h0);
        cyc("R8", 0, 1, 1, 1, 1, 1, 1, 10'h000, 18'h0);
        cyc("R8", 0, 1, 1, 1, 1, 1, 0, 10'h000, 18'h0);

        // R9: write right after a read releases at the first edge
        cyc("R9", 0, 0, 1, 1, 1, 1, 0, 10'h080, 18'h0);
        cyc("R9", 0, 1, 1, 0, 0, 1, 0, 10'h000, 18'h0ABCD);
        cyc("R9", 0, 1, 1, 1, 1, 1, 0, 10'h000, 18'h0);

        // R10: deselect keeps the last read driven one more edge
        cyc("R10", 0, 0, 1, 1, 1, 1, 0, 10'h090, 18'h0);
        cyc("R10", 1, 1, 0, 1, 1, 1, 0, 10'h000, 18'h0);
        cyc("R10", 1, 1, 1, 1, 1, 1, 0, 10'h000, 18'h0);
        cyc("R10", 0, 1, 1, 1, 1, 1, 0, 10'h000, 18'h0);

        // R7: random starts, advances, suspends, byte writes and deselects
        for (int k = 0; k < 4000; k++) begin
            int r;
            logic c, p, s, a, wa, wb, o;
            r  = int'($urandom % 16);
            wa = ($urandom % 3) != 0;
            wb = ($urandom % 3) != 0;
            a  = $urandom % 2;
            o  = ($urandom % 8) == 0;
            if (r < 3)      begin c = 0; p = 0; s = $urandom % 2; end
            else if (r < 6) begin c = 0; p = 1; s = 0; end
            else if (r < 7) begin c = 1; p = $urandom % 2; s = 0; end
            else            begin c = ($urandom % 4) == 0; p = $urandom % 2; s = 1;
                                  if (!c) p = 1; end
            cyc("R7", c, p, s, a, wa, wb, o, AW'($urandom), DW'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule